// File: doc/BRIEF.md
# Octet-Parallel Self-Synchronizing Scrambler (x^43 + 1)

This block scrambles or descrambles a byte stream eight bits per clock with the self-synchronizing polynomial x^43 + 1. Each accepted octet is combined, bit by bit, with taps from a 43-stage history register. The register is then advanced by eight positions in a single cycle. Working on whole octets lets the logic run at one eighth of the serial line rate.

One select input picks the direction. When scrambling, the register is fed with the bits the block sends out. When descrambling, it is fed with the bits it receives. A descrambler therefore holds the last 43 received line bits after 43 bits, whatever its starting state, and from then on it undoes the scrambling with no alignment step. The result of each accepted octet appears on the registered output one cycle later, flagged by a valid strobe.

Top module: `scr43_top`

## Requirements
- R1: While `rstN` is low and after it is released, `outValid` is 0 and `outData` is 0. The history register starts cleared, so the first octet accepted after reset comes out unchanged in either direction.
- R2: Stages are numbered 1 to 43, with stage 1 holding the newest bit. Bit 0 of an octet is the first bit in line order. Output bit i (i = 0..7) equals input bit i XOR the value stage 43−i held before the octet.
- R3: With `dirSel` = 0 (scramble), stage j (j = 1..8) is loaded with output bit 8−j of the accepted octet, and each stage j ≥ 9 takes the old value of stage j−8.
- R4: With `dirSel` = 1 (descramble), the history register advances in the same way as in R3. The difference is that stages 1..8 take input bit 8−j, the received bit, in place of the output bit.
- R5: An octet is accepted only in a cycle where `en` and `inValid` are both 1. In any other cycle the history register and `outData` keep their values, and `outValid` is 0 on the following cycle.
- R6: `outValid` is 1 exactly in the cycle after an accepted octet, and `outData` then carries that octet's result.
- R7: `dirSel` is sampled with each accepted octet. Changing it between consecutive octets changes only that octet's feedback source, and the history continues without a break.
- R8: A descrambler fed with scrambler output reproduces the original data from every octet after bit 48 onward (the 7th octet and later), whatever the two history registers held at the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable; gates acceptance |
| dirSel | input | 1 | 0 = scramble, 1 = descramble |
| inValid | input | 1 | Input octet qualifier |
| inData | input | 8 | Input octet, bit 0 first on the line |
| outValid | output | 1 | Result octet qualifier |
| outData | output | 8 | Result octet, bit 0 first on the line |

## Verification
The assertions check several relations on every cycle. They cover the one-cycle latency and quiet of the valid strobe, and the freezing of state and output on idle cycles. They also check the feedback source for each direction, comparing the newest eight history stages with either the registered output or the previous input octet, and the eight-place shift of the older stages. Only the bench's scenarios can show that each output bit is mixed with the correct tap in line order, that mode changes between octets keep the history intact, and that a descrambler recovers plaintext from a scrambler whose starting state it never saw. The bench does this by running a bit-serial reference model alongside the block and by pairing the block with an independently seeded model scrambler.

// File: rtl/scr43_pkg.sv
package scr43_pkg;
  localparam int unsigned HIST_LEN = 43;
  localparam int unsigned LANE_W   = 8;

  typedef struct packed {
    logic advance;     // octet accepted this cycle
    logic descramble;  // feedback taken from received bits
  } scr_strobe_t;
endpackage

// File: rtl/scr43_ctrl.sv
module scr43_ctrl
  import scr43_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        en,
  input  logic        inValid,
  input  logic        dirSel,
  output scr_strobe_t strobe
);
  always_comb begin
    strobe.advance    = rstN & en & inValid;
    strobe.descramble = dirSel;
  end

  AST_NO_ADV_IN_RESET: assert property (@(posedge clk) !rstN |-> !strobe.advance); // R1
endmodule

// File: rtl/scr43_dp.sv
module scr43_dp
  import scr43_pkg::*;
#(
  parameter int unsigned STAGES = HIST_LEN,
  parameter int unsigned WIDTH  = LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  scr_strobe_t      strobe,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] outData,
  output logic             outValid
);
  localparam int unsigned KEEP = STAGES - WIDTH;

  logic [STAGES-1:0] hist;      // hist[k] is stage k+1
  logic [STAGES-1:0] histNext;
  logic [WIDTH-1:0]  keyBits;
  logic [WIDTH-1:0]  mixed;
  logic [WIDTH-1:0]  fbBits;
  logic [WIDTH-1:0]  newestRev;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : gLane
      assign keyBits[g]   = hist[STAGES-1-g];
      assign histNext[g]  = fbBits[WIDTH-1-g];
      assign newestRev[g] = hist[WIDTH-1-g];
    end
  endgenerate

  assign mixed  = inData ^ keyBits;
  assign fbBits = strobe.descramble ? inData : mixed;
  assign histNext[STAGES-1:WIDTH] = hist[KEEP-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist     <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.advance;
      if (strobe.advance) begin
        hist    <= histNext;
        outData <= mixed;
      end
    end
  end

  AST_SCR_FEEDBACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.descramble |=> newestRev == outData); // R3
  AST_DSC_FEEDBACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && strobe.descramble |=> newestRev == $past(inData)); // R4
  AST_OLD_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> hist[STAGES-1:WIDTH] == $past(hist[KEEP-1:0])); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(hist) && $stable(outData)); // R5
endmodule

// File: rtl/scr43_top.sv
module scr43_top
  import scr43_pkg::*;
#(
  parameter int unsigned STAGES = HIST_LEN,
  parameter int unsigned WIDTH  = LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             dirSel,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData
);
  scr_strobe_t strobe;

  scr43_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .en     (en),
    .inValid(inValid),
    .dirSel (dirSel),
    .strobe (strobe)
  );

  scr43_dp #(.STAGES(STAGES), .WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData),
    .outValid(outValid)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    en && inValid |=> outValid); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(en && inValid) |=> !outValid); // R5
endmodule

// File: tb/scr43_top_test.sv
module scr43_top_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, en, dirSel, inValid;
  logic [7:0] inData;
  logic       outValid;
  logic [7:0] outData;

  int compared = 0;
  int mismatched = 0;
  logic [43:1] refSt;
  logic        expV;
  logic [7:0]  expD;
  string       lastTag;

  scr43_top uut (
    .clk(clk), .rstN(rstN), .en(en), .dirSel(dirSel), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  // bit-serial reference: stage 43 is the oldest bit, stage 1 the newest
  task automatic refStep(input logic [7:0] d, input logic descr,
                         inout logic [43:1] st, output logic [7:0] o);
    logic b;
    for (int i = 0; i < 8; i++) begin
      o[i] = d[i] ^ st[43];
      b    = descr ? d[i] : o[i];
      st   = {st[42:1], b};
    end
  endtask

  task automatic checkOut(input string tag);
    compared++;
    if (outValid !== expV || outData !== expD) begin
      mismatched++;
      $display("FAIL %s: outValid=%b outData=%h expected outValid=%b outData=%h",
               tag, outValid, outData, expV, expD);
    end
  endtask

  task automatic drive(input logic e, input logic v, input logic m,
                       input logic [7:0] d, input string tag);
    logic [7:0] o;
    en = e; inValid = v; dirSel = m; inData = d;
    if (e && v) begin
      refStep(d, m, refSt, o);
      expV = 1'b1;
      expD = o;
    end else begin
      expV = 1'b0;
    end
    lastTag = tag;
  endtask

  task automatic step(input logic e, input logic v, input logic m,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    checkOut(lastTag);
    drive(e, v, m, d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [43:1] auxSt;
    logic [7:0]  plain [0:31];
    logic [7:0]  cip;
    rstN = 1'b0; en = 1'b0; dirSel = 1'b0; inValid = 1'b0; inData = 8'h00;
    refSt = '0; expV = 1'b0; expD = 8'h00; lastTag = "R1";
    // R1: reset with stimulus asserted must not produce output
    repeat (2) begin
      @(negedge clk); checkOut("R1");
      en = 1'b1; inValid = 1'b1; inData = 8'h5C;
    end
    @(negedge clk); checkOut("R1");
    rstN = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 8'h00, "R1");
    // R1: first octet passes unchanged
    step(1'b1, 1'b1, 1'b0, 8'hC3, "R1");
    // R2/R3: scramble several patterns
    step(1'b1, 1'b1, 1'b0, 8'hFF, "R3");
    step(1'b1, 1'b1, 1'b0, 8'h00, "R3");
    step(1'b1, 1'b1, 1'b0, 8'hA5, "R2");
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 1'b0, 8'(k * 29 + 3), "R2");
    // R5: gaps of both kinds, data changing
    step(1'b1, 1'b0, 1'b0, 8'h77, "R5");
    step(1'b0, 1'b1, 1'b1, 8'h12, "R5");
    step(1'b0, 1'b0, 1'b0, 8'hE1, "R5");
    step(1'b1, 1'b1, 1'b0, 8'h3C, "R5");
    step(1'b1, 1'b0, 1'b1, 8'h99, "R6");
    step(1'b1, 1'b1, 1'b0, 8'h81, "R6");
    // R4: descramble patterns
    for (int k = 0; k < 16; k++) step(1'b1, 1'b1, 1'b1, 8'(k * 53 + 7), "R4");
    step(1'b1, 1'b1, 1'b1, 8'hFF, "R4");
    // R7: mode toggling between consecutive octets
    for (int k = 0; k < 16; k++) step(1'b1, 1'b1, 1'(k % 2), 8'(k * 91 + 5), "R7");
    for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 1'(k / 3), 8'(k * 17 + 200), "R7");
    // R8: model scrambler with its own start state feeds the block in descramble mode
    auxSt = 43'h5A5_F00D_CAFE;
    for (int k = 0; k < 32; k++) plain[k] = 8'(k * 37 + 11);
    for (int k = 0; k <= 24; k++) begin
      @(negedge clk);
      checkOut(lastTag);
      if (k >= 7) begin
        compared++;
        if (outData !== plain[k-1]) begin
          mismatched++;
          $display("FAIL R8: octet %0d outData=%h expected %h", k - 1, outData, plain[k-1]);
        end
      end
      if (k < 24) begin
        refStep(plain[k], 1'b0, auxSt, cip);
        drive(1'b1, 1'b1, 1'b1, cip, "R8");
      end else begin
        drive(1'b0, 1'b0, 1'b0, 8'h00, "R5");
      end
    end
    step(1'b0, 1'b0, 1'b0, 8'h00, "R5");
    @(negedge clk); checkOut(lastTag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule